// File: doc/BRIEF.md
# Register-Write Command Sequencer

This block runs a fixed list of commands without help from the host processor. It takes 32-bit command words from a show-ahead command FIFO and runs them strictly in the order they arrive. It never branches and never reads anything back. A command either writes 25 bits of data to one of 64 word-addressed registers on a write-only bus, or it is a timer command. A timer command either stalls the engine for a set number of clock cycles or starts a free-running timeout counter. The host preloads the FIFO and sets the enable. The engine then runs until one of its own writes clears the enable bit in its configuration register, or until it finds the FIFO empty while stop-on-empty is selected.

A programmable post-write delay adds a fixed pause after each register write. This means a waveform can be built from write words alone, with no wait word between them. A halt input freezes all progress for debug. A small parameterized set of register addresses is protected: writes to those addresses are consumed but never reach the bus. Each consumed command is reported by a one-cycle strobe that carries the command word.

Top module: `cmdSequencer`

## Requirements
- R1: After reset, fifoPop, regWrEn, cmdStrobe, seqActive, endIrq and tmoDone are all low.
- R2: A word with bit 31 = 1 is a write. In the cycle after it is popped, regWrEn is high with regWrAddr = word[30:25] and regWrData = word[24:0]. The only exception is a protected address (see R8).
- R3: A word with bits [31:30] = 00 is a wait of N = word[29:0] cycles. The fetch and decode cycles are part of N, so the next pop comes N cycles after the wait's pop. N of 0 or 1 gives 1 cycle.
- R4: After a write, the next pop comes 1 + postWriteDelay cycles after the write's pop. After a timeout word (bits [31:30] = 01), the next pop comes 1 cycle later.
- R5: The engine pops nothing and stays inactive until a hostEnSet pulse is seen while it is idle.
- R6: A write to address CFG_ADDR (default 0x20) with data bit 0 = 0 ends the sequence. endIrq pulses for one cycle in the same cycle as that command's strobe, and seqActive goes low.
- R7: While running with the FIFO empty, the engine ends the sequence with endIrq when stopOnEmpty = 1. When stopOnEmpty = 0 it stays active and waits for more words.
- R8: A write to a protected address (default 0x3B, 0x3C, 0x3D, 0x3E) is popped and strobed, but regWrEn stays low.
- R9: While haltIn = 1, the engine does not pop and the wait, post-write and timeout counters hold. Each halted cycle lengthens the current wait by one cycle.
- R10: A timeout word with N = word[29:0] makes tmoDone pulse N cycles after that word's strobe. tmoLate is raised with it if the sequence is still active at that point.
- R11: If hostEnSet arrives in the same cycle that a self-disabling write is popped, the host wins: the engine stays active and endIrq is not raised.
- R12: Every popped word produces one cmdStrobe cycle with cmdWord equal to that word, in FIFO order.
- R13: A hostEnClr pulse aborts the sequence. seqActive goes low, endIrq is not raised, and a running timeout is cleared so that tmoDone never pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostEnSet | input | 1 | Host pulse that starts the engine |
| hostEnClr | input | 1 | Host pulse that aborts the engine |
| haltIn | input | 1 | Freezes all progress while high |
| stopOnEmpty | input | 1 | End the sequence when the FIFO runs dry |
| postWriteDelay | input | DELAY_W | Extra cycles inserted after each write |
| fifoEmpty | input | 1 | Command FIFO has no word |
| fifoWord | input | 32 | Head word of the FIFO (show-ahead) |
| fifoPop | output | 1 | Consumes the head word at this edge |
| regWrEn | output | 1 | Register bus write strobe |
| regWrAddr | output | 6 | Register word address |
| regWrData | output | 25 | Register write data |
| cmdStrobe | output | 1 | One cycle per consumed command |
| cmdWord | output | 32 | Command word carried with cmdStrobe |
| seqActive | output | 1 | Engine is running |
| endIrq | output | 1 | End-of-sequence pulse |
| tmoDone | output | 1 | Timeout period elapsed |
| tmoLate | output | 1 | Sequence still running when the timeout elapsed |

## Verification
The assertions assume that fifoWord is stable and meaningful whenever fifoEmpty is low. They also assume that hostEnSet and hostEnClr are never raised together. The bench models the FIFO as an array read from a pointer that moves only on fifoPop, and it drives the two host pulses only in separate phases. The assertions also assume that haltIn changes only between clock edges. The bench therefore changes haltIn and every other input only on the falling edge.

// File: rtl/seqPkg.sv
package seqPkg;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 25;

  typedef struct packed {
    logic pop;       // head word consumed this edge
    logic freeze;    // halt: hold all counters
    logic tmoClear;  // host abort: drop the timeout
    logic seqOn;     // engine currently active
  } seqStrb_t;
endpackage

// File: rtl/seqCtrl.sv
module seqCtrl
  import seqPkg::*;
#(
  parameter int DELAY_W = 8,
  parameter int TIME_W = 30,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 6'h20
) (
  input  logic clk,
  input  logic rstN,
  input  logic hostEnSet,
  input  logic hostEnClr,
  input  logic haltIn,
  input  logic stopOnEmpty,
  input  logic [DELAY_W-1:0] postWriteDelay,
  input  logic fifoEmpty,
  input  logic [WORD_W-1:0] fifoWord,
  output logic seqActive,
  output logic endIrq,
  output seqStrb_t strb
);
  typedef enum logic [1:0] {IDLE, RUN, WAIT} state_t;

  state_t state;
  logic [TIME_W-1:0] waitCnt;

  logic isWrite, isTimeout, selfOff, canFetch, popNow, emptyStop;
  logic [TIME_W-1:0] timeField, waitLoad, delayLoad;
  logic unusedBits;

  assign isWrite   = fifoWord[31];
  assign isTimeout = !fifoWord[31] && fifoWord[30];
  assign timeField = fifoWord[TIME_W-1:0];
  assign selfOff   = isWrite && (fifoWord[30:25] == CFG_ADDR) && !fifoWord[0];
  assign waitLoad  = (timeField > TIME_W'(1)) ? timeField - TIME_W'(1) : '0;
  assign delayLoad = TIME_W'(postWriteDelay);
  assign unusedBits = ^fifoWord[24:1];

  assign canFetch  = (state == RUN) && !haltIn && !hostEnClr;
  assign popNow    = canFetch && !fifoEmpty;
  assign emptyStop = canFetch && fifoEmpty && stopOnEmpty && !hostEnSet;

  assign seqActive     = (state != IDLE);
  assign strb.pop      = popNow;
  assign strb.freeze   = haltIn;
  assign strb.tmoClear = hostEnClr;
  assign strb.seqOn    = seqActive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= IDLE;
      waitCnt <= '0;
      endIrq  <= 1'b0;
    end else begin
      endIrq <= 1'b0;
      if (hostEnClr) begin
        state <= IDLE;
      end else begin
        if (popNow) begin
          if (isWrite) begin
            if (selfOff && !hostEnSet) begin
              state  <= IDLE;
              endIrq <= 1'b1;
            end else if (delayLoad != '0) begin
              state   <= WAIT;
              waitCnt <= delayLoad;
            end
          end else if (!isTimeout && waitLoad != '0) begin
            state   <= WAIT;
            waitCnt <= waitLoad;
          end
        end else if (emptyStop) begin
          state  <= IDLE;
          endIrq <= 1'b1;
        end else if (state == WAIT && !haltIn) begin
          waitCnt <= waitCnt - TIME_W'(1);
          if (waitCnt == TIME_W'(1)) state <= RUN;
        end
        if (hostEnSet && state == IDLE) state <= RUN;
      end
    end
  end

  // R5
  start_by_host_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(state != IDLE) |-> $past(hostEnSet));

  // R6
  end_irq_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    endIrq |-> (!seqActive && $past(state != IDLE)));

  // R9
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (haltIn && state == WAIT && !hostEnClr) |=> ($stable(waitCnt) && state == WAIT));
endmodule

// File: rtl/seqDatapath.sv
module seqDatapath
  import seqPkg::*;
#(
  parameter int TIME_W = 30,
  parameter int PROT_N = 4,
  parameter logic [PROT_N*ADDR_W-1:0] PROT_LIST = {6'h3E, 6'h3D, 6'h3C, 6'h3B}
) (
  input  logic clk,
  input  logic rstN,
  input  seqStrb_t strb,
  input  logic [WORD_W-1:0] fifoWord,
  output logic regWrEn,
  output logic [ADDR_W-1:0] regWrAddr,
  output logic [DATA_W-1:0] regWrData,
  output logic cmdStrobe,
  output logic [WORD_W-1:0] cmdWord,
  output logic tmoDone,
  output logic tmoLate
);
  logic [PROT_N-1:0] hitVec;
  logic [TIME_W-1:0] tmoCnt;
  logic tmoRun, writeOk, tmoStart;

  for (genvar i = 0; i < PROT_N; i++) begin : g_prot
    assign hitVec[i] = (fifoWord[30:25] == PROT_LIST[i*ADDR_W +: ADDR_W]);
  end

  assign writeOk  = strb.pop && fifoWord[31] && !(|hitVec);
  assign tmoStart = strb.pop && !fifoWord[31] && fifoWord[30];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regWrEn   <= 1'b0;
      regWrAddr <= '0;
      regWrData <= '0;
      cmdStrobe <= 1'b0;
      cmdWord   <= '0;
    end else begin
      cmdStrobe <= strb.pop;
      regWrEn   <= writeOk;
      if (strb.pop) cmdWord <= fifoWord;
      if (writeOk) begin
        regWrAddr <= fifoWord[30:25];
        regWrData <= fifoWord[DATA_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmoCnt  <= '0;
      tmoRun  <= 1'b0;
      tmoDone <= 1'b0;
      tmoLate <= 1'b0;
    end else begin
      tmoDone <= 1'b0;
      tmoLate <= 1'b0;
      if (strb.tmoClear) begin
        tmoCnt <= '0;
        tmoRun <= 1'b0;
      end else if (tmoStart) begin
        tmoCnt <= fifoWord[TIME_W-1:0];
        tmoRun <= (fifoWord[TIME_W-1:0] != '0);
      end else if (tmoRun && !strb.freeze) begin
        tmoCnt <= tmoCnt - TIME_W'(1);
        if (tmoCnt == TIME_W'(1)) begin
          tmoRun  <= 1'b0;
          tmoDone <= 1'b1;
          tmoLate <= strb.seqOn;
        end
      end
    end
  end

  function automatic logic isProt(input logic [ADDR_W-1:0] a);
    logic hit = 1'b0;
    for (int k = 0; k < PROT_N; k++)
      if (PROT_LIST[k*ADDR_W +: ADDR_W] == a) hit = 1'b1;
    return hit;
  endfunction

  // R2
  wr_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> (cmdStrobe && cmdWord[31] && regWrAddr == cmdWord[30:25]
                 && regWrData == cmdWord[DATA_W-1:0]));

  // R8
  prot_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdStrobe && cmdWord[31] && isProt(cmdWord[30:25])) |-> !regWrEn);

  // R10
  tmo_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    tmoDone |=> !tmoDone);

  // R10
  tmo_late_chk: assert property (@(posedge clk) disable iff (!rstN)
    tmoLate |-> tmoDone);
endmodule

// File: rtl/cmdSequencer.sv
module cmdSequencer
  import seqPkg::*;
#(
  parameter int DELAY_W = 8,
  parameter int TIME_W = 30,
  parameter logic [5:0] CFG_ADDR = 6'h20,
  parameter int PROT_N = 4,
  parameter logic [PROT_N*6-1:0] PROT_LIST = {6'h3E, 6'h3D, 6'h3C, 6'h3B}
) (
  input  logic clk,
  input  logic rstN,
  input  logic hostEnSet,
  input  logic hostEnClr,
  input  logic haltIn,
  input  logic stopOnEmpty,
  input  logic [DELAY_W-1:0] postWriteDelay,
  input  logic fifoEmpty,
  input  logic [31:0] fifoWord,
  output logic fifoPop,
  output logic regWrEn,
  output logic [5:0] regWrAddr,
  output logic [24:0] regWrData,
  output logic cmdStrobe,
  output logic [31:0] cmdWord,
  output logic seqActive,
  output logic endIrq,
  output logic tmoDone,
  output logic tmoLate
);
  seqStrb_t strb;

  assign fifoPop = strb.pop;

  seqCtrl #(.DELAY_W(DELAY_W), .TIME_W(TIME_W), .CFG_ADDR(CFG_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostEnSet(hostEnSet), .hostEnClr(hostEnClr),
    .haltIn(haltIn), .stopOnEmpty(stopOnEmpty), .postWriteDelay(postWriteDelay),
    .fifoEmpty(fifoEmpty), .fifoWord(fifoWord), .seqActive(seqActive),
    .endIrq(endIrq), .strb(strb)
  );

  seqDatapath #(.TIME_W(TIME_W), .PROT_N(PROT_N), .PROT_LIST(PROT_LIST)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .fifoWord(fifoWord),
    .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regWrData(regWrData),
    .cmdStrobe(cmdStrobe), .cmdWord(cmdWord), .tmoDone(tmoDone), .tmoLate(tmoLate)
  );
endmodule

// File: tb/sim_cmdSequencer.sv
`timescale 1ns/1ps
module sim_cmdSequencer;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN, hostEnSet, hostEnClr, haltIn, stopOnEmpty;
  logic [7:0] postWriteDelay;
  logic fifoEmpty, fifoPop, regWrEn, cmdStrobe, seqActive, endIrq, tmoDone, tmoLate;
  logic [31:0] fifoWord, cmdWord;
  logic [5:0] regWrAddr;
  logic [24:0] regWrData;

  cmdSequencer u0 (
    .clk(clk), .rstN(rstN), .hostEnSet(hostEnSet), .hostEnClr(hostEnClr),
    .haltIn(haltIn), .stopOnEmpty(stopOnEmpty), .postWriteDelay(postWriteDelay),
    .fifoEmpty(fifoEmpty), .fifoWord(fifoWord), .fifoPop(fifoPop),
    .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regWrData(regWrData),
    .cmdStrobe(cmdStrobe), .cmdWord(cmdWord), .seqActive(seqActive),
    .endIrq(endIrq), .tmoDone(tmoDone), .tmoLate(tmoLate)
  );

  // FIFO model
  logic [31:0] fifoMem [0:63];
  int wrPtr = 0;
  int rdPtr = 0;
  assign fifoEmpty = (rdPtr == wrPtr);
  assign fifoWord  = fifoMem[rdPtr[5:0]];
  always @(posedge clk) if (fifoPop) rdPtr <= rdPtr + 1;

  // event log
  int cyc = 0, nStr = 0, nEnd = 0, endAt = -1, tmoAt = -1;
  bit tmoLateSeen = 0;
  int strCyc [0:63];
  logic [31:0] strWord [0:63];
  bit strWr [0:63];
  logic [5:0] strAddr [0:63];
  logic [24:0] strData [0:63];

  always @(negedge clk) begin
    cyc++;
    if (cmdStrobe && nStr < 64) begin
      strCyc[nStr] = cyc; strWord[nStr] = cmdWord; strWr[nStr] = regWrEn;
      strAddr[nStr] = regWrAddr; strData[nStr] = regWrData;
      nStr++;
    end
    if (endIrq) begin nEnd++; endAt = cyc; end
    if (tmoDone) begin tmoAt = cyc; tmoLateSeen = tmoLate; end
  end

  int nChecks = 0, nFails = 0;
  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clearLog();
    @(posedge clk); #1;
    nStr = 0; nEnd = 0; endAt = -1; tmoAt = -1; tmoLateSeen = 0;
  endtask

  task automatic push(input logic [31:0] w);
    @(negedge clk);
    fifoMem[wrPtr[5:0]] = w;
    wrPtr++;
  endtask

  task automatic startPulse();
    @(negedge clk); hostEnSet = 1'b1;
    @(negedge clk); hostEnSet = 1'b0;
  endtask

  typedef struct packed {
    logic [31:0] cmd;
    logic [7:0]  gap;
    logic        wr;
    logic [5:0]  addr;
    logic [24:0] data;
  } vec_t;

  // post-write delay 2
  localparam vec_t VECS [0:7] = '{
    '{32'h8A000123, 8'd3, 1'b1, 6'h05, 25'h0000123},
    '{32'h00000006, 8'd6, 1'b0, 6'h00, 25'h0},
    '{32'hFC000055, 8'd3, 1'b0, 6'h00, 25'h0},
    '{32'h00000001, 8'd1, 1'b0, 6'h00, 25'h0},
    '{32'h00000000, 8'd1, 1'b0, 6'h00, 25'h0},
    '{32'h4000000A, 8'd1, 1'b0, 6'h00, 25'h0},
    '{32'h93ABCDEF, 8'd3, 1'b1, 6'h09, 25'h1ABCDEF},
    '{32'hC0000000, 8'd0, 1'b1, 6'h20, 25'h0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) fifoMem[i] = '0;
    rstN = 1'b0; hostEnSet = 1'b0; hostEnClr = 1'b0; haltIn = 1'b0;
    stopOnEmpty = 1'b0; postWriteDelay = 8'd2;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!fifoPop && !regWrEn && !cmdStrobe, "R1 outputs", {fifoPop, regWrEn, cmdStrobe}, 0);
    chk(!seqActive && !endIrq && !tmoDone, "R1 status", {seqActive, endIrq, tmoDone}, 0);
    rstN = 1'b1;

    // table walk
    for (int i = 0; i < 8; i++) push(VECS[i].cmd);
    repeat (5) @(posedge clk);
    chk(rdPtr == 0, "R5 no pop while idle", rdPtr, 0);
    chk(!seqActive, "R5 inactive", seqActive, 0);
    clearLog();
    startPulse();
    repeat (60) @(posedge clk);
    chk(nStr == 8, "R12 strobe count", nStr, 8);
    for (int i = 0; i < 8; i++) begin
      chk(strWord[i] == VECS[i].cmd, "R12 word order", strWord[i], VECS[i].cmd);
      if (VECS[i].wr) begin
        chk(strWr[i] == 1'b1, "R2 write issued", strWr[i], 1);
        chk({strAddr[i], strData[i]} == {VECS[i].addr, VECS[i].data}, "R2 addr/data",
            {strAddr[i], strData[i]}, {VECS[i].addr, VECS[i].data});
      end else begin
        chk(strWr[i] == 1'b0, "R8 no bus write", strWr[i], 0);
      end
      if (i < 7)
        chk(strCyc[i+1] - strCyc[i] == int'(VECS[i].gap),
            VECS[i].cmd[31] ? "R4 gap" : "R3 gap", strCyc[i+1] - strCyc[i], VECS[i].gap);
    end
    chk(endAt == strCyc[7], "R6 end with strobe", endAt, strCyc[7]);
    chk(!seqActive, "R6 stopped", seqActive, 0);
    chk(tmoAt == strCyc[5] + 10, "R10 timeout cycle", tmoAt, strCyc[5] + 10);
    chk(tmoLateSeen == 1'b0, "R10 not late", tmoLateSeen, 0);

    // R7: empty without stop waits, with stop ends
    clearLog();
    startPulse();
    repeat (5) @(posedge clk);
    chk(seqActive && nEnd == 0, "R7 waits on empty", {seqActive, nEnd[0]}, 2'b10);
    push(32'h86000007);
    repeat (5) @(posedge clk);
    chk(nStr == 1 && strWr[0], "R7 late word executed", nStr, 1);
    @(negedge clk); stopOnEmpty = 1'b1;
    repeat (4) @(posedge clk);
    chk(nEnd == 1 && !seqActive, "R7 stop on empty", nEnd, 1);

    // R9: halt stretches a wait of 8 by 5 cycles
    clearLog();
    push(32'h00000008);
    push(32'h00000000);
    startPulse();
    @(negedge clk); haltIn = 1'b1;
    repeat (5) @(negedge clk);
    haltIn = 1'b0;
    repeat (20) @(posedge clk);
    chk(strCyc[1] - strCyc[0] == 13, "R9 halted wait", strCyc[1] - strCyc[0], 13);
    chk(nEnd == 1, "R9 sequence still ends", nEnd, 1);

    // R10: timeout expires while still running
    clearLog();
    push(32'h40000003);
    push(32'h00000014);
    startPulse();
    repeat (30) @(posedge clk);
    chk(tmoAt - strCyc[0] == 3, "R10 short timeout", tmoAt - strCyc[0], 3);
    chk(tmoLateSeen == 1'b1, "R10 late flag", tmoLateSeen, 1);

    // R11: host set beats self-disable in the same cycle
    stopOnEmpty = 1'b0;
    clearLog();
    push(32'hC0000000);
    @(negedge clk); hostEnSet = 1'b1;
    @(negedge clk);
    @(negedge clk); hostEnSet = 1'b0;
    repeat (3) @(posedge clk);
    chk(nStr == 1, "R11 word consumed", nStr, 1);
    chk(seqActive && nEnd == 0, "R11 host wins", {seqActive, nEnd[0]}, 2'b10);

    // R13: host abort clears sequence and timeout
    clearLog();
    push(32'h40000032);
    repeat (3) @(posedge clk);
    chk(nStr == 1, "R13 timeout started", nStr, 1);
    @(negedge clk); hostEnClr = 1'b1;
    @(negedge clk); hostEnClr = 1'b0;
    repeat (70) @(posedge clk);
    chk(!seqActive, "R13 aborted", seqActive, 0);
    chk(nEnd == 0 && tmoAt == -1, "R13 no irq, no timeout", {nEnd, tmoAt}, {32'd0, -32'sd1});

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule